// File: doc/BRIEF.md
# Branch Target Address Generator

This block works out where instruction fetch goes after a branch in a 32-bit instruction set whose instructions are always word aligned. Each request carries the address of the branch, its decoded fields and the current link and count register values. The block returns the next fetch address, whether the branch was taken, and the write-back values for the link and count registers. The condition bit is evaluated elsewhere and arrives as a single input. Prediction and condition timing are handled by other logic.

Four branch forms are encoded on `br_form`: `2'b00` is an unconditional branch with an immediate, `2'b01` is a conditional branch with an immediate, `2'b10` is a conditional branch through the link register, and `2'b11` is a conditional branch through the count register. The immediate forms can be relative or absolute, which gives six addressing modes in all.

Requests enter on a valid/ready handshake and results leave on another. The result appears one cycle after acceptance. While a result is valid and `res_ready` is low, the result is held unchanged and `req_ready` stays low. A new request can be accepted in the same cycle that the previous result is consumed.

Top module: `bta_gen`

## Requirements
- R1: The low two bits of `res_next` and of `res_lr_val` are always zero, whatever the computed value.
- R2: For form `2'b00` with `br_abs`=0, the target is `req_cia` plus `br_li` shifted left by 2 and sign-extended from bit 25. The branch is always taken and the count register is never written.
- R3: When `br_abs`=1 in an immediate form, the target is the shifted, sign-extended displacement alone, and `req_cia` is not added.
- R4: Form `2'b01` uses `br_bd` shifted left by 2 and sign-extended from bit 15. It is taken only when both the count test and the condition test pass. Otherwise `res_next` is `req_cia`+4.
- R5: Form `2'b10` takes its target from `req_lr` with the low two bits cleared.
- R6: Form `2'b11` takes its target from `req_ctr` with the low two bits cleared. In this form `br_dec` is ignored: the count register is not written and the count test counts as passed.
- R7: When `br_link`=1, `res_lr_we` is 1 and `res_lr_val` is `req_cia`+4. A link-register branch that also links still jumps to the old `req_lr`.
- R8: When `br_dec`=1 in forms `2'b01` or `2'b10`, `res_ctr_we` is 1 and `res_ctr_val` is `req_ctr`-1. The count test passes when (`req_ctr`-1 == 0) equals `br_zero`. A count of 0 wraps to all ones, which is nonzero.
- R9: When `br_use_cc`=0, `cc_met` has no effect on the outcome.
- R10: `req_ready` = !`res_valid` || `res_ready`. An accepted request shows its result one cycle later. A stalled result keeps `res_valid` high and holds all of its fields stable.
- R11: After reset, `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_cia | input | 32 | Address of the branch instruction |
| br_form | input | 2 | Branch form code |
| br_abs | input | 1 | Absolute addressing for immediate forms |
| br_link | input | 1 | Write return address to link register |
| br_dec | input | 1 | Decrement and test the count register |
| br_zero | input | 1 | Count test passes on zero (1) or nonzero (0) |
| br_use_cc | input | 1 | Condition bit takes part in the decision |
| br_li | input | 24 | Unconditional word displacement |
| br_bd | input | 14 | Conditional word displacement |
| cc_met | input | 1 | Condition bit matches the wanted value |
| req_lr | input | 32 | Current link register |
| req_ctr | input | 32 | Current count register |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_next | output | 32 | Next fetch address |
| res_taken | output | 1 | Branch taken |
| res_lr_we | output | 1 | Link register write enable |
| res_lr_val | output | 32 | Link register write value |
| res_ctr_we | output | 1 | Count register write enable |
| res_ctr_val | output | 32 | Count register write value |

## Verification
The hardest case to reach is a decrement whose result lands exactly on zero or wraps from zero, combined with a link-register branch that also links. That combination is where old and new register values could get mixed up. The stimulus drives counts of 1, 0 and 2 against both zero-sense settings, with link-register targets that have their low bits set and with linking on. Meanwhile a repeating `res_ready` pattern stalls results, so the held outputs and the refused requests get exercised at the same time.

// File: rtl/bta_pkg.sv
package bta_pkg;
  typedef enum logic [1:0] {
    FORM_IMM       = 2'b00,
    FORM_IMM_COND  = 2'b01,
    FORM_VIA_LINK  = 2'b10,
    FORM_VIA_COUNT = 2'b11
  } bta_form_e;

  localparam int unsigned INSN_BYTES = 4;
endpackage

// File: rtl/bta_disp.sv
module bta_disp
  import bta_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned LI_W = 24,
  parameter int unsigned BD_W = 14
) (
  input  bta_form_e         form,
  input  logic [LI_W-1:0]   li,
  input  logic [BD_W-1:0]   bd,
  output logic [AW-1:0]     disp
);
  localparam int unsigned LI_PAD = AW - LI_W - 2;
  localparam int unsigned BD_PAD = AW - BD_W - 2;

  logic [AW-1:0] li_ext;
  logic [AW-1:0] bd_ext;

  assign li_ext = {{LI_PAD{li[LI_W-1]}}, li, 2'b00};
  assign bd_ext = {{BD_PAD{bd[BD_W-1]}}, bd, 2'b00};

  always_comb begin
    if (form == FORM_IMM) disp = li_ext;
    else                  disp = bd_ext;
  end
endmodule

// File: rtl/bta_cond.sv
module bta_cond
  import bta_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bta_form_e     form,
  input  logic          dec,
  input  logic          zero_sense,
  input  logic          use_cc,
  input  logic          cc_met,
  input  logic [AW-1:0] ctr,
  output logic          taken,
  output logic          ctr_we,
  output logic [AW-1:0] ctr_new
);
  logic dec_allowed;
  logic ctr_hit;
  logic ctr_ok;
  logic cc_ok;

  assign dec_allowed = dec && (form == FORM_IMM_COND || form == FORM_VIA_LINK);
  assign ctr_new     = ctr - AW'(1);
  assign ctr_hit     = (ctr_new == '0);
  assign ctr_ok      = !dec_allowed || (ctr_hit == zero_sense);
  assign cc_ok       = !use_cc || cc_met;
  assign ctr_we      = dec_allowed;

  always_comb begin
    if (form == FORM_IMM) taken = 1'b1;
    else                  taken = ctr_ok && cc_ok;
  end

  AST_UNCOND_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (form == FORM_IMM) |-> (taken && !ctr_we)); // R2

  AST_COUNT_NO_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (form == FORM_VIA_COUNT) |-> !ctr_we); // R6
endmodule

// File: rtl/bta_target.sv
module bta_target
  import bta_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  bta_form_e     form,
  input  logic          abs_mode,
  input  logic          taken,
  input  logic [AW-1:0] cia,
  input  logic [AW-1:0] disp,
  input  logic [AW-1:0] lr,
  input  logic [AW-1:0] ctr,
  output logic [AW-1:0] next_addr,
  output logic [AW-1:0] seq_addr
);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(INSN_BYTES - 1);

  logic [AW-1:0] raw_target;
  logic [AW-1:0] imm_base;

  assign imm_base = abs_mode ? '0 : cia;
  assign seq_addr = (cia + AW'(INSN_BYTES)) & ALIGN_MASK;

  always_comb begin
    unique case (form)
      FORM_IMM, FORM_IMM_COND: raw_target = imm_base + disp;
      FORM_VIA_LINK:           raw_target = lr;
      default:                 raw_target = ctr;
    endcase
  end

  assign next_addr = taken ? (raw_target & ALIGN_MASK) : seq_addr;
endmodule

// File: rtl/bta_gen.sv
module bta_gen
  import bta_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned LI_W = 24,
  parameter int unsigned BD_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_cia,
  input  logic [1:0]      br_form,
  input  logic            br_abs,
  input  logic            br_link,
  input  logic            br_dec,
  input  logic            br_zero,
  input  logic            br_use_cc,
  input  logic [LI_W-1:0] br_li,
  input  logic [BD_W-1:0] br_bd,
  input  logic            cc_met,
  input  logic [AW-1:0]   req_lr,
  input  logic [AW-1:0]   req_ctr,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [AW-1:0]   res_next,
  output logic            res_taken,
  output logic            res_lr_we,
  output logic [AW-1:0]   res_lr_val,
  output logic            res_ctr_we,
  output logic [AW-1:0]   res_ctr_val
);
  bta_form_e     form;
  logic [AW-1:0] disp;
  logic          taken_c;
  logic          ctr_we_c;
  logic [AW-1:0] ctr_new_c;
  logic [AW-1:0] next_c;
  logic [AW-1:0] seq_c;
  logic          accept;

  assign form = bta_form_e'(br_form);

  bta_disp #(.AW(AW), .LI_W(LI_W), .BD_W(BD_W)) u_disp (
    .form (form),
    .li   (br_li),
    .bd   (br_bd),
    .disp (disp)
  );

  bta_cond #(.AW(AW)) u_cond (
    .clk        (clk),
    .rst_n      (rst_n),
    .form       (form),
    .dec        (br_dec),
    .zero_sense (br_zero),
    .use_cc     (br_use_cc),
    .cc_met     (cc_met),
    .ctr        (req_ctr),
    .taken      (taken_c),
    .ctr_we     (ctr_we_c),
    .ctr_new    (ctr_new_c)
  );

  bta_target #(.AW(AW)) u_target (
    .form      (form),
    .abs_mode  (br_abs),
    .taken     (taken_c),
    .cia       (req_cia),
    .disp      (disp),
    .lr        (req_lr),
    .ctr       (req_ctr),
    .next_addr (next_c),
    .seq_addr  (seq_c)
  );

  assign req_ready = !res_valid || res_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_next    <= '0;
      res_taken   <= 1'b0;
      res_lr_we   <= 1'b0;
      res_lr_val  <= '0;
      res_ctr_we  <= 1'b0;
      res_ctr_val <= '0;
    end else begin
      if (accept) begin
        res_valid   <= 1'b1;
        res_next    <= next_c;
        res_taken   <= taken_c;
        res_lr_we   <= br_link;
        res_lr_val  <= seq_c;
        res_ctr_we  <= ctr_we_c;
        res_ctr_val <= ctr_new_c;
      end else if (res_ready) begin
        res_valid   <= 1'b0;
      end
    end
  end

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_next[1:0] == 2'b00 && res_lr_val[1:0] == 2'b00)); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_next) && $stable(res_taken)
                                   && $stable(res_ctr_val))); // R10

  AST_FALLTHRU_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_taken) |-> (res_next == res_lr_val)); // R4
endmodule

// File: tb/bta_gen_bench.sv
module bta_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_cia = '0;
  logic [1:0]  br_form = '0;
  logic        br_abs = 1'b0, br_link = 1'b0, br_dec = 1'b0, br_zero = 1'b0;
  logic        br_use_cc = 1'b0, cc_met = 1'b0;
  logic [23:0] br_li = '0;
  logic [13:0] br_bd = '0;
  logic [31:0] req_lr = '0, req_ctr = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [31:0] res_next, res_lr_val, res_ctr_val;
  logic        res_taken, res_lr_we, res_ctr_we;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit stall_on = 1'b0;

  typedef struct {
    logic [31:0] nxt;
    logic        tk;
    logic        lwe;
    logic [31:0] lval;
    logic        cwe;
    logic [31:0] cval;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  bta_gen u_bta_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cia(req_cia), .br_form(br_form), .br_abs(br_abs), .br_link(br_link),
    .br_dec(br_dec), .br_zero(br_zero), .br_use_cc(br_use_cc), .br_li(br_li),
    .br_bd(br_bd), .cc_met(cc_met), .req_lr(req_lr), .req_ctr(req_ctr),
    .res_valid(res_valid), .res_ready(res_ready), .res_next(res_next),
    .res_taken(res_taken), .res_lr_we(res_lr_we), .res_lr_val(res_lr_val),
    .res_ctr_we(res_ctr_we), .res_ctr_val(res_ctr_val)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    res_ready <= stall_on ? ((cyc % 3) != 1) : 1'b1;
  end

  function automatic exp_t model(input logic [1:0] f, input logic ab, input logic lk,
      input logic dc, input logic zs, input logic uc, input logic cm,
      input logic [31:0] cia, input logic [23:0] li, input logic [13:0] bd,
      input logic [31:0] lr, input logic [31:0] ctr, input string tag);
    exp_t e;
    logic [31:0] d, tgt, seq;
    logic dok, cok, decv;
    seq = (cia + 32'd4) & 32'hFFFF_FFFC;
    d = (f == 2'b00) ? {{6{li[23]}}, li, 2'b00} : {{16{bd[13]}}, bd, 2'b00};
    case (f)
      2'b00, 2'b01: tgt = ab ? d : cia + d;
      2'b10: tgt = lr;
      default: tgt = ctr;
    endcase
    decv = dc && (f == 2'b01 || f == 2'b10);
    dok = !decv || (((ctr - 32'd1) == 0) == zs);
    cok = !uc || cm;
    e.tk = (f == 2'b00) ? 1'b1 : (dok && cok);
    e.nxt = e.tk ? (tgt & 32'hFFFF_FFFC) : seq;
    e.lwe = lk;
    e.lval = seq;
    e.cwe = decv;
    e.cval = ctr - 32'd1;
    e.tag = tag;
    return e;
  endfunction

  task automatic send(input logic [1:0] f, input logic ab, input logic lk,
      input logic dc, input logic zs, input logic uc, input logic cm,
      input logic [31:0] cia, input logic [23:0] li, input logic [13:0] bd,
      input logic [31:0] lr, input logic [31:0] ctr, input string tag);
    @(negedge clk);
    br_form = f; br_abs = ab; br_link = lk; br_dec = dc; br_zero = zs;
    br_use_cc = uc; cc_met = cm; req_cia = cia; br_li = li; br_bd = bd;
    req_lr = lr; req_ctr = ctr; req_valid = 1'b1;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    sb.push_back(model(f, ab, lk, dc, zs, uc, cm, cia, li, bd, lr, ctr, tag));
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  // Monitor: a result is consumed at the next edge when valid and ready
  always @(negedge clk) begin
    #2;
    if (rst_n && res_valid && res_ready) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        failures++;
        $display("FAIL %s unexpected result next=%h expected none", "R10", res_next);
      end else begin
        e = sb.pop_front();
        if (res_next !== e.nxt || res_taken !== e.tk || res_lr_we !== e.lwe ||
            (e.lwe && res_lr_val !== e.lval) || res_ctr_we !== e.cwe ||
            (e.cwe && res_ctr_val !== e.cval)) begin
          failures++;
          $display("FAIL %s next=%h tk=%b lwe=%b lval=%h cwe=%b cval=%h expected next=%h tk=%b lwe=%b lval=%h cwe=%b cval=%h",
                   e.tag, res_next, res_taken, res_lr_we, res_lr_val, res_ctr_we, res_ctr_val,
                   e.nxt, e.tk, e.lwe, e.lval, e.cwe, e.cval);
        end
      end
    end
  end

  initial begin
    bit hung;
    hung = 1'b0;
    fork
      begin
        repeat (3) @(negedge clk);
        checks++;
        if (res_valid !== 1'b0) begin
          failures++;
          $display("FAIL R11 res_valid=%b expected 0", res_valid);
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R2 relative forward and backward
        send(2'b00, 0, 0, 0, 0, 0, 0, 32'h0000_1000, 24'h000010, 14'h0, 32'h0, 32'h0, "R2");
        send(2'b00, 0, 0, 1, 0, 0, 0, 32'h0000_1000, 24'hFFFFFF, 14'h0, 32'h0, 32'h5, "R2");
        // R3 absolute, negative displacement
        send(2'b00, 1, 0, 0, 0, 0, 0, 32'h8000_0000, 24'h800000, 14'h0, 32'h0, 32'h0, "R3");
        send(2'b01, 1, 0, 0, 0, 0, 0, 32'h4000_0000, 24'h0, 14'h2000, 32'h0, 32'h0, "R3");
        // R4 conditional immediate
        send(2'b01, 0, 0, 0, 0, 1, 1, 32'h0000_2000, 24'h0, 14'h1FFF, 32'h0, 32'h0, "R4");
        send(2'b01, 0, 0, 0, 0, 1, 0, 32'h0000_2000, 24'h0, 14'h0004, 32'h0, 32'h0, "R4");
        // R9 condition ignored
        send(2'b01, 0, 0, 0, 0, 0, 0, 32'h0000_3000, 24'h0, 14'h3FFF, 32'h0, 32'h0, "R9");
        // R5 link register target with low bits set
        send(2'b10, 0, 0, 0, 0, 1, 1, 32'h0000_4000, 24'h0, 14'h0, 32'h0000_9003, 32'h0, "R5");
        // R6 count register target, dec ignored
        send(2'b11, 0, 0, 1, 1, 0, 0, 32'h0000_5000, 24'h0, 14'h0, 32'h0, 32'h0000_7002, "R6");
        // R7 link with link-register target uses old value
        send(2'b10, 0, 1, 0, 0, 0, 0, 32'h0000_6000, 24'h0, 14'h0, 32'h0001_0000, 32'h0, "R7");
        send(2'b11, 0, 1, 0, 0, 0, 0, 32'hFFFF_FFFC, 24'h0, 14'h0, 32'h0, 32'h0000_0100, "R7");
        stall_on = 1'b1;
        // R8 count test corners
        send(2'b01, 0, 0, 1, 1, 0, 0, 32'h0000_7000, 24'h0, 14'h0040, 32'h0, 32'h1, "R8");
        send(2'b01, 0, 0, 1, 0, 0, 0, 32'h0000_7000, 24'h0, 14'h0040, 32'h0, 32'h1, "R8");
        send(2'b01, 0, 0, 1, 0, 0, 0, 32'h0000_7000, 24'h0, 14'h0040, 32'h0, 32'h0, "R8");
        send(2'b10, 0, 1, 1, 1, 0, 0, 32'h0000_8000, 24'h0, 14'h0, 32'h0000_A001, 32'h2, "R8");
        send(2'b10, 0, 1, 1, 0, 1, 1, 32'h0000_8000, 24'h0, 14'h0, 32'h0000_A001, 32'h2, "R8");
        // R10 back-to-back under stalls, R1 alignment
        for (int i = 0; i < 8; i++)
          send(2'b00, i[0], i[1], 0, 0, 0, 0, 32'h0000_0100 * i + 32'h3, 24'(i * 3 - 8), 14'h0,
               32'h0, 32'h0, "R10");
        send(2'b01, 0, 1, 0, 0, 1, 0, 32'h0000_0FFF, 24'h0, 14'h0001, 32'h0, 32'h0, "R1");
        stall_on = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
      end
      begin
        repeat (5000) @(posedge clk);
        hung = 1'b1;
      end
    join_any
    disable fork;
    if (hung) begin
      checks++;
      failures++;
      $display("FAIL R10 watchdog expired pending=%0d expected 0", sb.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule